// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a 32-bit tick counter with a companion control register. Both sit in the special-register space of a processor core, in group 10. An address is formed as `group << 11 | index`. Index 0 holds the control word and index 1 holds the count. Software selects one of four operating modes in the control word, sets a 28-bit match value, and enables or acknowledges an interrupt. The counter advances on cycles where the external tick enable is high and the timer is running.

When the low 28 bits of the count equal the match value on an advancing cycle, the pending flag is set. The mode then decides what the counter does next: it returns to zero, it halts, or it carries on. The interrupt output is the pending flag gated by the enable bit.

Two behaviours differ from a naive register file. First, the run state changes only when a write actually alters the mode field. Second, writing the pending bit as 1 leaves pending as it was, while writing it as 0 clears it.

Top module: `tick_timer`

## Requirements
- R1: Only the two addresses 0x5000 (control) and 0x5001 (count) are decoded. Writes to any other address change no state. Reads of any other address, and any cycle with the read strobe low, return 0.
- R2: The control word holds the mode in bits 31:30, interrupt enable in bit 29, pending in bit 28 and the match value in bits 27:0. A read returns the mode, enable and match exactly as they were last written.
- R3: While running, the count rises by one on each cycle with the tick enable high. It wraps from 0xFFFFFFFF to 0. On cycles without a tick it holds.
- R4: Run state changes only when a control write carries a mode different from the current one. The new run state is "running" unless the new mode is 00 (stop). A write that repeats the current mode leaves the run state alone.
- R5: A match on an advancing cycle sets pending. In mode 01 (restart) the count becomes 0 on that cycle.
- R6: In mode 10 (one-shot) a match stops the counter, and the count stays at the match value.
- R7: In mode 11 (continuous) a match does not disturb counting: the count moves past the match value.
- R8: A control write with bit 28 set keeps pending at its present value. A control write with bit 28 clear clears pending, and the interrupt output is low in the next cycle.
- R9: The interrupt output is high exactly when pending and interrupt enable are both set.
- R10: A count write loads the counter with the write data on the next cycle. A count read returns the current count combinationally.
- R11: After reset the control word and the count are 0, the timer is stopped and the interrupt output is low.
- R12: Match detection compares only bits 27:0 of the count. Bits 31:28 do not take part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Special-register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational, 0 when not selected |
| tick_en | input | 1 | Count-advance enable |
| irq | output | 1 | Timer interrupt request |

## Verification
Every cycle, the assertions check the following:
- a count write lands on the next cycle;
- the count holds when it is not advancing, and steps by one when it advances with no match;
- a restart match zeroes the count;
- a mode write to stop halts the counter, and rewriting the same mode keeps the run state;
- the pending keep and clear rules hold, and the interrupt never rises without pending.

Other behaviours only the bench scenarios can show. These are the one-shot halt, and the fact that rewriting the one-shot mode does not restart it. They also cover the match with high count bits set, the 32-bit wrap, and unmapped addresses being ignored. All of these depend on multi-step histories that the reference model follows.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    TM_STOP    = 2'b00,
    TM_RESTART = 2'b01,
    TM_ONESHOT = 2'b10,
    TM_CONT    = 2'b11
  } tmode_e;
endpackage

// File: rtl/tt_decode.sv
module tt_decode #(
  parameter int ADDR_W      = 16,
  parameter int GROUP       = 10,
  parameter int GROUP_SHIFT = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              mode_sel,
  output logic              cnt_sel,
  output logic              mode_we,
  output logic              cnt_we
);
  localparam int BASE = GROUP << GROUP_SHIFT;

  assign mode_sel = (addr == ADDR_W'(BASE));
  assign cnt_sel  = (addr == ADDR_W'(BASE + 1));
  assign mode_we  = wr_en && mode_sel;
  assign cnt_we   = wr_en && cnt_sel;
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int MATCH_W = DATA_W - 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [DATA_W-1:0]  wd,
  input  logic               hit,
  output tmode_e             mode_q,
  output logic               ie_q,
  output logic               pend_q,
  output logic [MATCH_W-1:0] match_q,
  output logic               mode_chg,
  output tmode_e             new_mode
);
  localparam int IE_BIT   = DATA_W - 3;
  localparam int PEND_BIT = DATA_W - 4;

  assign new_mode = tmode_e'(wd[DATA_W-1 -: 2]);
  assign mode_chg = we && (new_mode != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= TM_STOP;
      ie_q    <= 1'b0;
      pend_q  <= 1'b0;
      match_q <= '0;
    end else if (we) begin
      mode_q  <= new_mode;
      ie_q    <= wd[IE_BIT];
      match_q <= wd[MATCH_W-1:0];
      // a one in the pending field preserves, a zero acknowledges
      pend_q  <= wd[PEND_BIT] ? (pend_q | hit) : 1'b0;
    end else begin
      pend_q  <= pend_q | hit;
    end
  end
endmodule

// File: rtl/tt_count.sv
module tt_count
  import tt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int MATCH_W = DATA_W - 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_we,
  input  logic [DATA_W-1:0]  wd,
  input  logic               tick,
  input  logic               mode_chg,
  input  tmode_e             new_mode,
  input  tmode_e             mode_q,
  input  logic [MATCH_W-1:0] match_q,
  output logic [DATA_W-1:0]  count_q,
  output logic               run_q,
  output logic               hit
);
  logic adv;

  assign adv = run_q && tick;
  assign hit = adv && (count_q[MATCH_W-1:0] == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_we) begin
      count_q <= wd;
    end else if (adv) begin
      if (hit && mode_q == TM_RESTART)      count_q <= '0;
      else if (hit && mode_q == TM_ONESHOT) count_q <= count_q;
      else                                  count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               run_q <= 1'b0;
    else if (mode_chg)                        run_q <= (new_mode != TM_STOP);
    else if (hit && mode_q == TM_ONESHOT)     run_q <= 1'b0;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int GROUP       = 10,
  parameter int GROUP_SHIFT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_en,
  output logic              irq
);
  localparam int MATCH_W = DATA_W - 4;

  logic               mode_sel, cnt_sel, mode_we, cnt_we;
  tmode_e             mode_q, new_mode;
  logic               ie_q, pend_q, mode_chg, run_q, hit;
  logic [MATCH_W-1:0] match_q;
  logic [DATA_W-1:0]  count_q;

  tt_decode #(.ADDR_W(ADDR_W), .GROUP(GROUP), .GROUP_SHIFT(GROUP_SHIFT)) u_dec (
    .addr(reg_addr), .wr_en(wr_en), .mode_sel(mode_sel), .cnt_sel(cnt_sel),
    .mode_we(mode_we), .cnt_we(cnt_we)
  );

  tt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .wd(wr_data), .hit(hit),
    .mode_q(mode_q), .ie_q(ie_q), .pend_q(pend_q), .match_q(match_q),
    .mode_chg(mode_chg), .new_mode(new_mode)
  );

  tt_count #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .wd(wr_data), .tick(tick_en),
    .mode_chg(mode_chg), .new_mode(new_mode), .mode_q(mode_q),
    .match_q(match_q), .count_q(count_q), .run_q(run_q), .hit(hit)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en && mode_sel)     rd_data = {mode_q, ie_q, pend_q, match_q};
    else if (rd_en && cnt_sel) rd_data = count_q;
  end

  assign irq = pend_q && ie_q;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int DATA_W = 32,
  localparam int MATCH_W = DATA_W - 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_we,
  input logic               cnt_we,
  input logic [DATA_W-1:0]  wr_data,
  input logic               tick_en,
  input logic               irq,
  input logic [1:0]         mode_q,
  input logic               run_q,
  input logic               pend_q,
  input logic [MATCH_W-1:0] match_q,
  input logic [DATA_W-1:0]  count_q
);
  logic adv, at_match;
  assign adv      = run_q && tick_en;
  assign at_match = count_q[MATCH_W-1:0] == match_q;

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count_q == $past(wr_data));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && !adv) |=> $stable(count_q));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && adv && !at_match) |=> count_q == $past(count_q) + 1'b1);

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && !mode_we && adv && at_match && mode_q == 2'b01)
      |=> (count_q == '0) && pend_q);

  p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && wr_data[DATA_W-1 -: 2] == 2'b00) |=> !run_q);

  p_same_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && wr_data[DATA_W-1 -: 2] == mode_q && !adv)
      |=> run_q == $past(run_q));

  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && wr_data[DATA_W-4] && pend_q) |=> pend_q);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !wr_data[DATA_W-4]) |=> !irq);

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend_q);
endmodule

bind tick_timer tt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .cnt_we(cnt_we),
  .wr_data(wr_data), .tick_en(tick_en), .irq(irq), .mode_q(mode_q),
  .run_q(run_q), .pend_q(pend_q), .match_q(match_q), .count_q(count_q)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  localparam logic [15:0] MA = 16'h5000;
  localparam logic [15:0] CA = 16'h5001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0, fails = 0, cyc = 0;

  // reference model state
  logic [1:0]  m_mode = 2'b00;
  logic        m_ie = 1'b0, m_pend = 1'b0, m_run = 1'b0;
  logic [27:0] m_match = '0;
  logic [31:0] m_cnt = '0;

  always #2 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .tick_en(tick_en), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] model_read(input logic [15:0] a);
    if (a == MA) return {m_mode, m_ie, m_pend, m_match};
    if (a == CA) return m_cnt;
    return 32'h0;
  endfunction

  task automatic model_update(input logic [15:0] a, input logic we,
                              input logic [31:0] wd, input logic tk);
    bit hit, adv;
    logic [31:0] n_cnt;
    bit n_run, n_pend;
    adv = m_run && tk;
    hit = adv && (m_cnt[27:0] == m_match);
    n_cnt = m_cnt; n_run = m_run; n_pend = m_pend || hit;
    if (adv) begin
      if (hit && m_mode == 2'b01) n_cnt = 0;
      else if (hit && m_mode == 2'b10) n_run = 0;
      else n_cnt = m_cnt + 1;
    end
    if (we && a == CA) n_cnt = wd;
    if (we && a == MA) begin
      if (wd[31:30] != m_mode) n_run = (wd[31:30] != 2'b00);
      if (!wd[28]) n_pend = 0;
      m_mode = wd[31:30]; m_ie = wd[29]; m_match = wd[27:0];
    end
    m_cnt = n_cnt; m_run = n_run; m_pend = n_pend;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, advance model at posedge, compare irq
  task automatic step(input logic [15:0] a, input logic we, input logic [31:0] wd,
                      input logic re, input logic tk, input string tag);
    reg_addr = a; wr_en = we; wr_data = wd; rd_en = re; tick_en = tk;
    #1;
    if (re) check(rd_data, model_read(a), tag);
    else    check(rd_data, 32'h0, {tag, " idle read"});
    @(posedge clk);
    model_update(a, we, wd, tk);
    @(negedge clk);
    check({31'h0, irq}, {31'h0, m_pend && m_ie}, {tag, " irq"});
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
    step(a, 1'b1, d, 1'b0, 1'b0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(16'h0, 1'b0, 32'h0, 1'b0, 1'b1, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(16'h0, 1'b0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; wr_en = 1'b0; rd_en = 1'b1; tick_en = 1'b0;
    #1;
    check(rd_data, exp, tag);
    step(a, 1'b0, 32'h0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check({31'h0, irq}, 32'h0, "R11 irq after reset");
    rd_chk(MA, 32'h0, "R11 control");
    rd_chk(CA, 32'h0, "R11 count");

    wr(MA, 32'hC000_0005, "R2 write continuous");
    rd_chk(MA, 32'hC000_0005, "R2 layout");
    ticks(3, "R3 advance");
    rd_chk(CA, 32'd3, "R3 three ticks");
    idle(2, "R3 no tick");
    rd_chk(CA, 32'd3, "R3 hold");
    ticks(3, "R7 pass match");
    rd_chk(CA, 32'd6, "R7 continuous past match");
    rd_chk(MA, 32'hD000_0005, "R5 pending set, R9 irq low with ie 0");

    wr(MA, 32'hF000_0005, "R8 keep pending, R9 irq");
    rd_chk(MA, 32'hF000_0005, "R8 pending kept");
    ticks(1, "R4 same mode runs");
    rd_chk(CA, 32'd7, "R4 still running");
    wr(MA, 32'hE000_0005, "R8 clear pending");
    rd_chk(MA, 32'hE000_0005, "R8 cleared");

    wr(MA, 32'h2000_0005, "R4 stop");
    ticks(2, "R4 stopped");
    rd_chk(CA, 32'd7, "R4 count frozen");

    wr(CA, 32'h1000_0002, "R10 load");
    rd_chk(CA, 32'h1000_0002, "R10 live read");
    wr(MA, 32'h6000_0005, "R5 restart mode");
    ticks(4, "R12 high bits ignored");
    rd_chk(CA, 32'h0, "R5 restart to zero");
    rd_chk(MA, 32'h7000_0005, "R12 match with high count bits");

    wr(MA, 32'h8000_0002, "R6 one-shot");
    ticks(5, "R6 run to match");
    rd_chk(CA, 32'd2, "R6 halted at match");
    rd_chk(MA, 32'h9000_0002, "R6 pending");
    wr(MA, 32'h9000_0002, "R4 same one-shot mode");
    ticks(2, "R4 stays halted");
    rd_chk(CA, 32'd2, "R4 no restart");
    wr(MA, 32'hC000_0002, "R4 mode change restarts");
    ticks(1, "R7 tick at match");
    rd_chk(CA, 32'd3, "R7 continued");
    rd_chk(MA, 32'hD000_0002, "R7 pending on match");

    wr(16'h5002, 32'hFFFF_FFFF, "R1 unmapped write");
    wr(16'h4800, 32'hFFFF_FFFF, "R1 other group write");
    rd_chk(16'h5002, 32'h0, "R1 unmapped read");
    rd_chk(MA, 32'hD000_0002, "R1 control untouched");
    rd_chk(CA, 32'd3, "R1 count untouched");

    wr(CA, 32'hFFFF_FFFF, "R10 load max");
    ticks(1, "R3 wrap");
    rd_chk(CA, 32'h0, "R3 wrapped to zero");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule